// File: doc/BRIEF.md
# Windowed Service Watchdog Monitor

This block is a small watchdog peripheral reached over a byte-wide register bus. Once software enables it, an internal counter advances on every clock. Software keeps the watchdog output low by writing a two-byte key to the service register. The key is honoured only while the counter sits inside a window bounded by a low and a high compare value. A late key, an early key, a wrong byte, a counter that runs past the high bound, or an active level on an optional external input all assert the watchdog output. Once asserted, the output stays high until reset.

The enable, input-enable and input-polarity settings and both compare bounds can each be set exactly once after reset. A later write that tries to change them is rejected with a bus error in the same cycle. The interrupt-enable bit stays writable. An interrupt request follows the watchdog output while that bit is set, so software can silence the request without clearing the fault. The bus is a single-cycle valid/write/address interface: read data and the error flag are produced combinationally in the cycle of the request, and writes take effect at the next rising edge.

Top module: `wdg_window_mon`

## Requirements
- R1: Registers sit at bus offsets 0 (control), 1 (service key), 2 (window low) and 3 (window high). Control bit 0 is the monitor enable, bit 1 is the external-input active level (0 means low is active), bit 2 is the external-input enable and bit 3 is the interrupt enable; bits 7:4 read as zero. After reset, control reads 0x00, window low reads 0x00, window high reads 0xFF, and the watchdog output and interrupt request are low.
- R2: Each window register accepts its first write after reset. Every later write to it raises bus_err in that cycle and leaves the stored value unchanged.
- R3: The first control write after reset is always accepted. A later control write that would change bit 0, 1 or 2 raises bus_err and is discarded as a whole. A later control write that keeps those three bits unchanged is accepted without error and updates bit 3.
- R4: Reads never raise bus_err. A read of the service register returns 0x00. Writes to the service register never raise bus_err.
- R5: The counter starts from zero at the edge of the control write that first sets the enable bit. While the monitor is not enabled, including when the first control write leaves bit 0 clear, service writes and the external input have no effect and the watchdog output stays low.
- R6: With window high set to H below 0xFF and no service, the watchdog output is low after the (H+1)-th rising edge following the enabling edge and high after the (H+2)-th.
- R7: With window high at 0xFF the counter saturates and never expires; the output stays low without service.
- R8: A service is a write of 0xB4 followed by a write of 0x2C to the service register. A service completed while the counter is at least window low and at most window high returns the counter to zero and leaves the output low.
- R9: A service completed while the counter is below window low asserts the watchdog output.
- R10: A service-register write of any value other than 0xB4 when no key is pending, or of any value other than 0x2C as the second byte, asserts the watchdog output.
- R11: The second byte is accepted if its write comes at most SERVICE_CYCLES clock cycles after the first byte's write. If no second byte arrives by then, the watchdog output asserts.
- R12: When input enable is set, ext_in at the selected active level asserts the watchdog output. When input enable is clear, ext_in is ignored.
- R13: Once asserted, the watchdog output remains high until reset.
- R14: The interrupt request is high exactly when the watchdog output is high and the interrupt-enable bit is set. Clearing that bit drops the request while the output stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the request cycle |
| bus_err | output | 1 | Transfer error, in the request cycle |
| ext_in | input | 1 | External fault input |
| wdg_out | output | 1 | Watchdog output, high when asserted |
| irq | output | 1 | Interrupt request |

## Verification
Most internal state can only be seen through the timing of wdg_out, so a counter that is off by one cycle is caught by sampling the output on both sides of the expiry edge and by completing services just inside and just outside the inter-byte limit. A lock flag that was set wrongly shows up at once as a bus_err, or as a missing one, on the repeated write and as a changed readback. A key sequencer stuck in the wrong state turns a legal service into a fault one cycle after the second byte. A lost reset of the counter by a service shows only later, as an expiry that arrives too early.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int CTRL_BITS = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_KEY  = 2'd1,
        SEL_WLO  = 2'd2,
        SEL_WHI  = 2'd3
    } reg_sel_e;

    localparam logic [DATA_W-1:0] KEY_OPEN  = 8'hB4;
    localparam logic [DATA_W-1:0] KEY_CLOSE = 8'h2C;
    localparam logic [DATA_W-1:0] WLO_INIT  = 8'h00;
    localparam logic [DATA_W-1:0] WHI_INIT  = 8'hFF;

    // Field order matches the bit positions software sees (bit 3 .. bit 0).
    typedef struct packed {
        logic irq_en;
        logic in_en;
        logic in_pol;
        logic mon_en;
    } ctrl_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_OPEN
    } seq_state_e;

    typedef struct packed {
        logic ok;
        logic bad;
    } svc_evt_t;

    function automatic logic [DATA_W-1:0] ctrl_to_byte(ctrl_t c);
        return {{(DATA_W-CTRL_BITS){1'b0}}, c};
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [DATA_W-1:0] b);
        return ctrl_t'(b[CTRL_BITS-1:0]);
    endfunction

    // True when a later control write would alter a locked field.
    function automatic logic ctrl_clash(ctrl_t cur, ctrl_t nxt);
        return (cur.mon_en != nxt.mon_en) || (cur.in_pol != nxt.in_pol) ||
               (cur.in_en != nxt.in_en);
    endfunction

endpackage

// File: rtl/wdm_regs.sv
module wdm_regs
    import wdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    output ctrl_t               cfg,
    output logic [DATA_W-1:0]   wlo,
    output logic [DATA_W-1:0]   whi,
    output logic                arm,
    output logic                key_wr,
    output logic [DATA_W-1:0]   key_data
);

    reg_sel_e sel;
    logic     wr_req;
    logic     rd_req;
    ctrl_t    ctrl_new;
    logic     ctrl_done;
    logic     wlo_done;
    logic     whi_done;
    logic     ctrl_hit;
    logic     wlo_hit;
    logic     whi_hit;
    logic     ctrl_bad;

    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        wr_req   = bus_valid && bus_write;
        rd_req   = bus_valid && !bus_write;
        ctrl_new = byte_to_ctrl(bus_wdata);
        ctrl_hit = wr_req && (sel == SEL_CTRL);
        wlo_hit  = wr_req && (sel == SEL_WLO);
        whi_hit  = wr_req && (sel == SEL_WHI);
        ctrl_bad = ctrl_hit && ctrl_done && ctrl_clash(cfg, ctrl_new);
        bus_err  = ctrl_bad || (wlo_hit && wlo_done) || (whi_hit && whi_done);
        arm      = ctrl_hit && !ctrl_done && ctrl_new.mon_en;
        key_wr   = wr_req && (sel == SEL_KEY);
        key_data = bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_req) begin
            unique case (sel)
                SEL_CTRL: bus_rdata = ctrl_to_byte(cfg);
                SEL_KEY:  bus_rdata = '0;
                SEL_WLO:  bus_rdata = wlo;
                SEL_WHI:  bus_rdata = whi;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            ctrl_done <= 1'b0;
            wlo       <= WLO_INIT;
            whi       <= WHI_INIT;
            wlo_done  <= 1'b0;
            whi_done  <= 1'b0;
        end else begin
            if (ctrl_hit && !ctrl_bad) begin
                cfg       <= ctrl_new;
                ctrl_done <= 1'b1;
            end
            if (wlo_hit && !wlo_done) begin
                wlo      <= bus_wdata;
                wlo_done <= 1'b1;
            end
            if (whi_hit && !whi_done) begin
                whi      <= bus_wdata;
                whi_done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdm_keyseq.sv
module wdm_keyseq
    import wdm_pkg::*;
#(
    parameter int SERVICE_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output svc_evt_t          evt
);

    localparam int TMR_W = $clog2(SERVICE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(SERVICE_CYCLES);

    seq_state_e       state;
    seq_state_e       state_nxt;
    logic [TMR_W-1:0] tmr;

    always_comb begin
        evt       = '0;
        state_nxt = state;
        unique case (state)
            SEQ_IDLE: begin
                if (key_wr) begin
                    if (key_data == KEY_OPEN) state_nxt = SEQ_OPEN;
                    else                      evt.bad   = 1'b1;
                end
            end
            SEQ_OPEN: begin
                if (key_wr) begin
                    state_nxt = SEQ_IDLE;
                    if (key_data == KEY_CLOSE) evt.ok  = 1'b1;
                    else                       evt.bad = 1'b1;
                end else if (tmr == TMR_LIMIT) begin
                    state_nxt = SEQ_IDLE;
                    evt.bad   = 1'b1;
                end
            end
            default: state_nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_nxt;
            if (state == SEQ_IDLE) tmr <= TMR_W'(1);
            else if (!key_wr && tmr != TMR_LIMIT) tmr <= tmr + TMR_W'(1);
        end
    end

endmodule

// File: rtl/wdm_core.sv
module wdm_core
    import wdm_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  ctrl_t             cfg,
    input  svc_evt_t          evt,
    input  logic [CNT_W-1:0]  wlo,
    input  logic [CNT_W-1:0]  whi,
    input  logic              ext_in,
    output logic              wdg_out
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic             in_window;
    logic             expired;
    logic             ext_hit;
    logic             fault;

    always_comb begin
        in_window = (cnt >= wlo) && (cnt <= whi);
        expired   = cnt > whi;
        ext_hit   = cfg.in_en && (ext_in == cfg.in_pol);
        fault     = cfg.mon_en &&
                    (expired || evt.bad || (evt.ok && !in_window) || ext_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt     <= '0;
            wdg_out <= 1'b0;
        end else if (cfg.mon_en) begin
            wdg_out <= wdg_out || fault;
            if (evt.ok && in_window) cnt <= '0;
            else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_window_mon.sv
module wdg_window_mon
    import wdm_pkg::*;
#(
    parameter int SERVICE_CYCLES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_err,
    input  logic        ext_in,
    output logic        wdg_out,
    output logic        irq
);

    ctrl_t             cfg;
    logic [DATA_W-1:0] wlo;
    logic [DATA_W-1:0] whi;
    logic              arm;
    logic              key_wr_raw;
    logic              key_wr;
    logic [DATA_W-1:0] key_data;
    svc_evt_t          evt;
    logic              mon_en;
    logic              irq_en;

    wdm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .cfg       (cfg),
        .wlo       (wlo),
        .whi       (whi),
        .arm       (arm),
        .key_wr    (key_wr_raw),
        .key_data  (key_data)
    );

    assign mon_en = cfg.mon_en;
    assign irq_en = cfg.irq_en;
    assign key_wr = key_wr_raw && mon_en;

    wdm_keyseq #(.SERVICE_CYCLES(SERVICE_CYCLES)) u_keyseq (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (key_data),
        .evt      (evt)
    );

    wdm_core #(.CNT_W(DATA_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .cfg     (cfg),
        .evt     (evt),
        .wlo     (wlo),
        .whi     (whi),
        .ext_in  (ext_in),
        .wdg_out (wdg_out)
    );

    assign irq = wdg_out && irq_en;

endmodule

// File: rtl/wdm_checker.sv
module wdm_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic       bus_write,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       bus_err,
    input logic       wdg_out,
    input logic       mon_en,
    input logic [7:0] wlo,
    input logic [7:0] whi
);

    assert_out_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        wdg_out |=> wdg_out);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !mon_en |-> !wdg_out);

    assert_enable_held_R3: assert property (@(posedge clk) disable iff (rst)
        mon_en |=> mon_en);

    assert_read_no_err_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |-> !bus_err);

    assert_key_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == 2'd1) |-> (bus_rdata == 8'h00));

    assert_whi_takes_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == 2'd3 && !bus_err)
        |=> (whi == $past(bus_wdata)));

    assert_err_keeps_window_R2: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> ($stable(wlo) && $stable(whi)));

endmodule

bind wdg_window_mon wdm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .wdg_out   (wdg_out),
    .mon_en    (mon_en),
    .wlo       (wlo),
    .whi       (whi)
);

// File: tb/wdg_window_mon_tb.sv
module wdg_window_mon_tb;

    localparam int SVC = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_err;
    logic       ext_in = 1'b1;
    logic       wdg_out;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdg_window_mon #(.SERVICE_CYCLES(SVC)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .ext_in    (ext_in),
        .wdg_out   (wdg_out),
        .irq       (irq)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] addr;
        logic [7:0] data;
        logic       err;
        logic       chk_rd;
        logic [7:0] rd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00},  // R1 control reset
        '{1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 8'h00},  // R1 window low reset
        '{1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 8'hFF},  // R1 window high reset
        '{1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 8'h00},  // R4 key reads zero
        '{1'b1, 2'd2, 8'h03, 1'b0, 1'b0, 8'h00},  // R2 first low write
        '{1'b1, 2'd2, 8'h05, 1'b1, 1'b0, 8'h00},  // R2 repeat low write
        '{1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 8'h03},  // R2 low kept
        '{1'b1, 2'd3, 8'hFE, 1'b0, 1'b0, 8'h00},  // R2 first high write
        '{1'b1, 2'd3, 8'h30, 1'b1, 1'b0, 8'h00},  // R2 repeat high write
        '{1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 8'hFE},  // R2 high kept
        '{1'b1, 2'd0, 8'hF9, 1'b0, 1'b0, 8'h00},  // R3 first control write
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h09},  // R1 reserved bits zero
        '{1'b1, 2'd0, 8'h0B, 1'b1, 1'b0, 8'h00},  // R3 polarity change refused
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h09},  // R3 unchanged
        '{1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 8'h00},  // R3 irq enable cleared
        '{1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h01},  // R3 readback
        '{1'b1, 2'd1, 8'hB4, 1'b0, 1'b0, 8'h00},  // R4 key write no error
        '{1'b1, 2'd1, 8'h2C, 1'b0, 1'b0, 8'h00}   // R4 R8 key close
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts at a falling edge, ends at the next falling edge.
    task automatic bus_op(input logic wr, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic er);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        rd = bus_rdata;
        er = bus_err;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] rd;
        logic er;
        bus_op(1'b1, a, d, rd, er);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic setup(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] ctl);
        do_reset();
        wr_reg(2'd2, lo);
        wr_reg(2'd3, hi);
        wr_reg(2'd0, ctl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic er;
        @(negedge clk);
        do_reset();
        check("R1 out after reset", {7'b0, wdg_out}, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, er);
            check($sformatf("R1-R4 vector %0d err", i), {7'b0, er}, {7'b0, VECS[i].err});
            if (VECS[i].chk_rd)
                check($sformatf("R1-R4 vector %0d rdata", i), rd, VECS[i].rd);
        end
        check("R8 in-window service", {7'b0, wdg_out}, 8'h00);

        // R6 expiry timing and R14 interrupt
        setup(8'h00, 8'h28, 8'h09);
        idle(41);
        check("R6 low before expiry", {7'b0, wdg_out}, 8'h00);
        idle(1);
        check("R6 high at expiry", {7'b0, wdg_out}, 8'h01);
        check("R14 irq with out", {7'b0, irq}, 8'h01);
        bus_op(1'b1, 2'd0, 8'h01, rd, er);
        check("R3 irq enable write ok", {7'b0, er}, 8'h00);
        check("R14 irq dropped", {7'b0, irq}, 8'h00);
        idle(5);
        check("R13 out sticky", {7'b0, wdg_out}, 8'h01);

        // R8 service inside window restarts count
        setup(8'h0A, 8'h28, 8'h01);
        idle(15);
        wr_reg(2'd1, 8'hB4);
        wr_reg(2'd1, 8'h2C);
        idle(30);
        check("R8 restart kept out low", {7'b0, wdg_out}, 8'h00);
        idle(15);
        check("R8 later expiry", {7'b0, wdg_out}, 8'h01);

        // R9 early service
        setup(8'h0A, 8'h28, 8'h01);
        wr_reg(2'd1, 8'hB4);
        wr_reg(2'd1, 8'h2C);
        check("R9 early service faults", {7'b0, wdg_out}, 8'h01);

        // R10 wrong bytes
        setup(8'h00, 8'hFE, 8'h01);
        wr_reg(2'd1, 8'hB4);
        wr_reg(2'd1, 8'h2D);
        check("R10 bad second byte", {7'b0, wdg_out}, 8'h01);
        setup(8'h00, 8'hFE, 8'h01);
        wr_reg(2'd1, 8'h2C);
        check("R10 bad first byte", {7'b0, wdg_out}, 8'h01);

        // R11 inter-byte limit
        setup(8'h00, 8'hFE, 8'h01);
        wr_reg(2'd1, 8'hB4);
        idle(SVC - 1);
        wr_reg(2'd1, 8'h2C);
        check("R11 second byte at limit", {7'b0, wdg_out}, 8'h00);
        setup(8'h00, 8'hFE, 8'h01);
        wr_reg(2'd1, 8'hB4);
        idle(SVC);
        wr_reg(2'd1, 8'h2C);
        check("R11 second byte late", {7'b0, wdg_out}, 8'h01);

        // R7 saturation with high bound 0xFF
        setup(8'h00, 8'hFF, 8'h01);
        idle(300);
        check("R7 never expires", {7'b0, wdg_out}, 8'h00);

        // R12 external input, both levels and gating
        ext_in = 1'b1;
        setup(8'h00, 8'hFE, 8'h05);
        idle(5);
        check("R12 inactive high level", {7'b0, wdg_out}, 8'h00);
        ext_in = 1'b0;
        idle(2);
        check("R12 active low level", {7'b0, wdg_out}, 8'h01);
        ext_in = 1'b0;
        setup(8'h00, 8'hFE, 8'h07);
        idle(5);
        check("R12 inactive low level", {7'b0, wdg_out}, 8'h00);
        ext_in = 1'b1;
        idle(2);
        check("R12 active high level", {7'b0, wdg_out}, 8'h01);
        setup(8'h00, 8'hFE, 8'h01);
        ext_in = 1'b0;
        idle(5);
        check("R12 input disabled low", {7'b0, wdg_out}, 8'h00);
        ext_in = 1'b1;
        idle(5);
        check("R12 input disabled high", {7'b0, wdg_out}, 8'h00);

        // R5 monitor left disabled
        do_reset();
        bus_op(1'b1, 2'd0, 8'h04, rd, er);
        check("R5 disabling write ok", {7'b0, er}, 8'h00);
        bus_op(1'b1, 2'd0, 8'h05, rd, er);
        check("R5 R3 late enable refused", {7'b0, er}, 8'h01);
        ext_in = 1'b0;
        wr_reg(2'd1, 8'h55);
        idle(300);
        check("R5 disabled stays low", {7'b0, wdg_out}, 8'h00);
        ext_in = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule